// File: doc/BRIEF.md
# Dual-Channel Lockstep Output Comparator

This block watches the result buses of two identical processing channels. The channels share one clock and run the same work. It checks them against each other on every clock cycle. One channel is the primary and the other is the checker. Each presents a result word together with a valid strobe. Whenever the two disagree, the block raises a request to move the system into a safe state.

Two comparison styles are supported, chosen by a skew setting. At zero skew the channels are compared cycle for cycle. At a non-zero skew the checker runs a fixed number of cycles behind the primary. A programmable delay line then holds back the primary result and its strobe, so that matching beats meet at the comparison point.

On the first disagreement since reset or the last clear, the block latches a sticky mismatch flag and emits a one-cycle safe-state request. A mode input, sampled at that moment, selects the response:
- a one-cycle system reset request, or
- a fail-safe level that stays high until cleared.

A saturating counter records how many cycles disagreed, for diagnostic reads.

Top module: `lockstep_cmp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are 0. The skew delay line holds no valid beat after reset.
- R2: With `skew_i` = 0, a cycle where both valid strobes are 1 and the data words differ sets `mismatch_o` after that clock edge. Equal words leave it at 0.
- R3: A cycle where exactly one of the two aligned valid strobes is 1 counts as a mismatch, whatever the data words are.
- R4: A cycle where both aligned valid strobes are 0 is not compared. Data differences in such cycles change no output.
- R5: With `skew_i` = d (0 to 7), the primary beat presented in cycle n is compared with the checker beat presented in cycle n+d. A checker stream delayed by exactly d produces no mismatch. A checker stream delayed by d-1 produces one.
- R6: `mismatch_o` is sticky. Only reset or a cycle with `clear_i` = 1 clears it. When a mismatch and `clear_i` occur in the same cycle, the mismatch wins and the flag stays 1.
- R7: `safe_req_o` is a one-cycle pulse in the cycle after the first mismatch since reset or the last clear. A mismatch in the same cycle as `clear_i` counts as a first mismatch.
- R8: If `fail_mode_i` = 0 in the detecting cycle, `reset_req_o` pulses together with `safe_req_o`, and `failsafe_o` is 0.
- R9: If `fail_mode_i` = 1 in the detecting cycle, `failsafe_o` goes to 1 and holds until `clear_i` or reset, and `reset_req_o` stays 0.
- R10: `err_count_o` adds one for every mismatching cycle and saturates at 255. `clear_i` sets it to 0, or to 1 if that same cycle mismatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both channels |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Clears the sticky flag, the fail-safe level and the counter |
| skew_i | input | 3 | Cycles by which the checker trails the primary (0 to 7) |
| fail_mode_i | input | 1 | Response select: 0 = reset request pulse, 1 = fail-safe level |
| pri_valid_i | input | 1 | Primary channel result strobe |
| pri_data_i | input | 32 | Primary channel result word |
| chk_valid_i | input | 1 | Checker channel result strobe |
| chk_data_i | input | 32 | Checker channel result word |
| mismatch_o | output | 1 | Sticky disagreement flag |
| safe_req_o | output | 1 | One-cycle safe-state request on first disagreement |
| reset_req_o | output | 1 | One-cycle system reset request (mode 0) |
| failsafe_o | output | 1 | Held fail-safe level (mode 1) |
| err_count_o | output | 8 | Saturating count of disagreeing cycles |

## Verification
The comparator is driven with four kinds of pattern. Identical valid streams show that agreement stays quiet. Single corrupted words separate data compares from strobe compares. Idle cycles carrying different garbage show that invalid beats are skipped. One-sided strobes show that a lone valid is caught.

For every skew from 1 to 7, a checker stream trailing by exactly the skew must pass, and the same stream trailing one cycle short must fail. This separates a correct delay tap from an off-by-one tap. A long run of corrupt beats drives the counter into saturation. A clear that coincides with a fault then checks the priority between set and clear, in both response modes.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Safe-state response selected when a disagreement is first latched
  typedef enum logic {
    RESP_RESET    = 1'b0,
    RESP_FAILSAFE = 1'b1
  } resp_mode_e;

endpackage

// File: rtl/lsc_skew_line.sv
// Programmable delay for the primary channel: tap 0 is the live input,
// tap k is the beat presented k cycles earlier.
module lsc_skew_line #(
  parameter int DATA_W   = 32,
  parameter int MAX_SKEW = 7,
  localparam int SKEW_W  = $clog2(MAX_SKEW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SKEW_W-1:0] skew_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              v_q [MAX_SKEW];
  logic [DATA_W-1:0] d_q [MAX_SKEW];
  logic [SKEW_W-1:0] sel;

  // Clamp out-of-range settings to the deepest tap
  assign sel = (int'(skew_i) > MAX_SKEW) ? SKEW_W'(MAX_SKEW) : skew_i;

  generate
    for (genvar g = 0; g < MAX_SKEW; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) v_q[g] <= 1'b0;
          else     v_q[g] <= valid_i;
          d_q[g] <= data_i;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) v_q[g] <= 1'b0;
          else     v_q[g] <= v_q[g-1];
          d_q[g] <= d_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    valid_o = valid_i;
    data_o  = data_i;
    for (int i = 0; i < MAX_SKEW; i++) begin
      if (int'(sel) == i + 1) begin
        valid_o = v_q[i];
        data_o  = d_q[i];
      end
    end
  end

endmodule

// File: rtl/lsc_compare.sv
// Beat comparison: lone strobe or differing valid words count as a fault.
module lsc_compare #(
  parameter int DATA_W = 32
) (
  input  logic              a_valid_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              b_valid_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic              diff_o
);

  logic strobe_diff;
  logic word_diff;

  assign strobe_diff = a_valid_i ^ b_valid_i;
  assign word_diff   = a_valid_i & b_valid_i & (a_data_i != b_data_i);
  assign diff_o      = strobe_diff | word_diff;

endmodule

// File: rtl/lsc_sat_counter.sv
module lsc_sat_counter #(
  parameter int CNT_W = 8,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] base;

  assign base = clear_i ? '0 : count_o;

  always_ff @(posedge clk) begin
    if (rst)                          count_o <= '0;
    else if (inc_i && base != CNT_MAX) count_o <= base + 1'b1;
    else                              count_o <= base;
  end

  // R10: a saturated count stays put until cleared
  a_r10_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (count_o == CNT_MAX && !clear_i) |=> (count_o == CNT_MAX));

  // R10: without clear the count never decreases
  a_r10_monotone: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> (count_o >= $past(count_o)));

endmodule

// File: rtl/lsc_response.sv
module lsc_response
  import lsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_i,
  input  logic       diff_i,
  input  resp_mode_e mode_i,
  output logic       mismatch_o,
  output logic       safe_req_o,
  output logic       reset_req_o,
  output logic       failsafe_o
);

  logic held;
  logic first_hit;
  logic fs_base;

  assign held      = clear_i ? 1'b0 : mismatch_o;
  assign fs_base   = clear_i ? 1'b0 : failsafe_o;
  assign first_hit = diff_i & ~held;

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch_o  <= 1'b0;
      safe_req_o  <= 1'b0;
      reset_req_o <= 1'b0;
      failsafe_o  <= 1'b0;
    end else begin
      mismatch_o  <= held | diff_i;
      safe_req_o  <= first_hit;
      reset_req_o <= first_hit & (mode_i == RESP_RESET);
      failsafe_o  <= fs_base | (first_hit & (mode_i == RESP_FAILSAFE));
    end
  end

  // R6: sticky flag survives until clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (mismatch_o && !clear_i) |=> mismatch_o);

  // R7: the safe request is a single-cycle pulse
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    (safe_req_o && !clear_i) |=> !safe_req_o);

  // R8: a reset request only accompanies a safe request
  a_r8_with_safe: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> safe_req_o);

  // R9: fail-safe level holds until clear
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (failsafe_o && !clear_i) |=> failsafe_o);

  // R9: the two responses never coexist
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> !failsafe_o);

  // R6: any response implies the sticky flag
  a_r6_flag_backs_resp: assert property (@(posedge clk) disable iff (rst)
    (safe_req_o || failsafe_o) |-> mismatch_o);

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int DATA_W   = 32,
  parameter int MAX_SKEW = 7,
  parameter int CNT_W    = 8,
  localparam int SKEW_W  = $clog2(MAX_SKEW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic [SKEW_W-1:0] skew_i,
  input  logic              fail_mode_i,
  input  logic              pri_valid_i,
  input  logic [DATA_W-1:0] pri_data_i,
  input  logic              chk_valid_i,
  input  logic [DATA_W-1:0] chk_data_i,
  output logic              mismatch_o,
  output logic              safe_req_o,
  output logic              reset_req_o,
  output logic              failsafe_o,
  output logic [CNT_W-1:0]  err_count_o
);
  import lsc_pkg::*;

  logic              al_valid;
  logic [DATA_W-1:0] al_data;
  logic              diff;
  resp_mode_e        mode;

  assign mode = resp_mode_e'(fail_mode_i);

  lsc_skew_line #(.DATA_W(DATA_W), .MAX_SKEW(MAX_SKEW)) u_skew (
    .clk     (clk),
    .rst     (rst),
    .skew_i  (skew_i),
    .valid_i (pri_valid_i),
    .data_i  (pri_data_i),
    .valid_o (al_valid),
    .data_o  (al_data)
  );

  lsc_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_valid_i (al_valid),
    .a_data_i  (al_data),
    .b_valid_i (chk_valid_i),
    .b_data_i  (chk_data_i),
    .diff_o    (diff)
  );

  lsc_response u_resp (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (clear_i),
    .diff_i      (diff),
    .mode_i      (mode),
    .mismatch_o  (mismatch_o),
    .safe_req_o  (safe_req_o),
    .reset_req_o (reset_req_o),
    .failsafe_o  (failsafe_o)
  );

  lsc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (clear_i),
    .inc_i   (diff),
    .count_o (err_count_o)
  );

  // R2: with no skew, both strobes high on differing words flags a fault
  a_r2_exact: assert property (@(posedge clk) disable iff (rst)
    (skew_i == '0 && pri_valid_i && chk_valid_i && pri_data_i != chk_data_i)
      |=> mismatch_o);

  // R3: a lone strobe at zero skew flags a fault
  a_r3_lone: assert property (@(posedge clk) disable iff (rst)
    (skew_i == '0 && (pri_valid_i != chk_valid_i)) |=> mismatch_o);

endmodule

// File: tb/lockstep_cmp_bench.sv
module lockstep_cmp_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        clear_i;
  logic [2:0]  skew_i;
  logic        fail_mode_i;
  logic        pri_valid_i, chk_valid_i;
  logic [31:0] pri_data_i, chk_data_i;
  logic        mismatch_o, safe_req_o, reset_req_o, failsafe_o;
  logic [7:0]  err_count_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_cmp u_lockstep_cmp (
    .clk(clk), .rst(rst), .clear_i(clear_i), .skew_i(skew_i),
    .fail_mode_i(fail_mode_i),
    .pri_valid_i(pri_valid_i), .pri_data_i(pri_data_i),
    .chk_valid_i(chk_valid_i), .chk_data_i(chk_data_i),
    .mismatch_o(mismatch_o), .safe_req_o(safe_req_o),
    .reset_req_o(reset_req_o), .failsafe_o(failsafe_o),
    .err_count_o(err_count_o)
  );

  // ---------------- behavioural reference model ----------------
  bit          hv [8];
  logic [31:0] hd [8];
  bit m_mis, m_safe, m_rreq, m_fs;
  int m_cnt;

  always @(posedge clk) begin
    bit av; logic [31:0] ad; bit diff, first;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin hv[i] = 0; hd[i] = '0; end
      m_mis = 0; m_safe = 0; m_rreq = 0; m_fs = 0; m_cnt = 0;
    end else begin
      if (skew_i == 0) begin av = pri_valid_i; ad = pri_data_i; end
      else begin av = hv[skew_i-1]; ad = hd[skew_i-1]; end
      diff  = (av != chk_valid_i) || (av && chk_valid_i && ad != chk_data_i);
      if (clear_i) begin m_mis = 0; m_fs = 0; m_cnt = 0; end
      first  = diff && !m_mis;
      m_safe = first;
      m_rreq = first && !fail_mode_i;
      if (first && fail_mode_i) m_fs = 1;
      if (diff) m_mis = 1;
      if (diff && m_cnt < 255) m_cnt++;
      for (int i = 7; i > 0; i--) begin hv[i] = hv[i-1]; hd[i] = hd[i-1]; end
      hv[0] = pri_valid_i; hd[0] = pri_data_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R6 mismatch_o vs model", int'(mismatch_o), int'(m_mis));
      chk("R7 safe_req_o vs model", int'(safe_req_o), int'(m_safe));
      chk("R8 reset_req_o vs model", int'(reset_req_o), int'(m_rreq));
      chk("R9 failsafe_o vs model", int'(failsafe_o), int'(m_fs));
      chk("R10 err_count_o vs model", int'(err_count_o), m_cnt);
    end
  end

  // watchdog
  initial begin
    wait (cycles > 100000);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic step(input bit pv, input logic [31:0] pd,
                      input bit cv, input logic [31:0] cd, input bit clr);
    pri_valid_i = pv; pri_data_i = pd;
    chk_valid_i = cv; chk_data_i = cd;
    clear_i     = clr;
    @(posedge clk); #1;
  endtask

  logic [31:0] sd [64];
  bit          sv [64];

  initial begin
    rst = 1'b1; clear_i = 0; skew_i = 0; fail_mode_i = 0;
    pri_valid_i = 0; chk_valid_i = 0; pri_data_i = 0; chk_data_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mismatch in reset", int'(mismatch_o), 0);
    chk("R1 count in reset", int'(err_count_o), 0);
    rst = 1'b0;
    step(0, 0, 0, 0, 0);
    chk("R1 outputs after reset",
        int'({mismatch_o, safe_req_o, reset_req_o, failsafe_o}), 0);

    // R2: equal streams at zero skew
    for (int n = 0; n < 20; n++) begin
      logic [31:0] w = $urandom;
      step(1, w, 1, w, 0);
    end
    chk("R2 equal words no mismatch", int'(mismatch_o), 0);
    step(1, 32'h1234, 1, 32'h1235, 0);
    chk("R2 differing word flags", int'(mismatch_o), 1);
    chk("R8 reset request pulse", int'(reset_req_o), 1);
    chk("R8 no failsafe in mode 0", int'(failsafe_o), 0);
    step(1, 5, 1, 5, 0);
    chk("R7 safe request single cycle", int'(safe_req_o), 0);
    chk("R6 sticky flag", int'(mismatch_o), 1);

    // R6 clear, R4 idle garbage ignored
    step(0, 0, 0, 0, 1);
    chk("R6 clear drops flag", int'(mismatch_o), 0);
    for (int n = 0; n < 10; n++) step(0, $urandom, 0, $urandom, 0);
    chk("R4 invalid beats ignored flag", int'(mismatch_o), 0);
    chk("R4 invalid beats ignored count", int'(err_count_o), 0);

    // R3 lone strobe
    step(1, 7, 0, 7, 0);
    chk("R3 lone primary strobe", int'(mismatch_o), 1);
    step(0, 0, 0, 0, 1);
    step(0, 9, 1, 9, 0);
    chk("R3 lone checker strobe", int'(mismatch_o), 1);
    step(0, 0, 0, 0, 1);

    // R9 fail-safe mode
    fail_mode_i = 1;
    step(1, 1, 1, 2, 0);
    chk("R9 failsafe set", int'(failsafe_o), 1);
    chk("R9 no reset request", int'(reset_req_o), 0);
    repeat (5) step(0, 0, 0, 0, 0);
    chk("R9 failsafe held", int'(failsafe_o), 1);
    step(0, 0, 0, 0, 1);
    chk("R9 failsafe cleared", int'(failsafe_o), 0);
    fail_mode_i = 0;

    // R5 time-diverse alignment for every skew
    for (int d = 1; d < 8; d++) begin
      skew_i = 3'(d);
      repeat (9) step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1);
      for (int n = 0; n < 40; n++) begin
        sv[n] = (n % 5 != 0);
        sd[n] = 32'hA000_0000 + 32'(n * 8 + d);
        step(sv[n], sd[n], (n >= d) ? sv[n-d] : 1'b0,
             (n >= d) ? sd[n-d] : 32'h0, 0);
      end
      chk($sformatf("R5 skew %0d aligned", d), int'(mismatch_o), 0);
      for (int n = 40; n < 60; n++) begin
        sv[n] = 1;
        sd[n] = 32'hB000_0000 + 32'(n);
        step(1, sd[n], sv[n-d+1], sd[n-d+1], 0);
      end
      chk($sformatf("R5 skew %0d short by one", d), int'(mismatch_o), 1);
    end
    skew_i = 0;
    repeat (9) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);

    // R10 saturation, then clear coinciding with a fault
    repeat (300) step(1, 1, 1, 2, 0);
    chk("R10 count saturates", int'(err_count_o), 255);
    step(1, 1, 1, 2, 1);
    chk("R10 clear with fault gives 1", int'(err_count_o), 1);
    chk("R6 fault wins over clear", int'(mismatch_o), 1);
    chk("R7 pulse after clear-with-fault", int'(safe_req_o), 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule